// File: doc/BRIEF.md
# System Control Status/Cause Exception Controller

This block holds the system control register set of a small 32-bit in-order core. It keeps the processor status word, the exception cause word and the exception return address. The pipeline writes and reads these registers through a simple indexed port. The block takes exception requests, including system call and breakpoint traps, together with the faulting PC and a branch-delay flag. It also raises a software interrupt on its own when the software-interrupt pending bits meet their mask bits while interrupts are globally enabled. A return-from-exception strobe restores the previous privilege and interrupt-enable level.

The status word carries a three-deep stack of {kernel/user, interrupt-enable} pairs in its low six bits. Taking an exception pushes the stack, so the current level becomes kernel with interrupts off. Returning pops it by one level. Each taken exception is reported for one cycle on `excTaken`, with the cause code on `excCodeOut`. The pipeline uses that code to pick its handler.

Top module: `exc_status_ctrl`

## Requirements
- R1: After reset every register reads 0 and `excTaken` is 0.
- R2: A write to any index other than 12 (status) and 13 (cause) stores the full 32-bit value. The register reads back unchanged through the combinational read port. Index 14 is the exception return address.
- R3: A write to cause (index 13) updates only bits 9:8, the software-interrupt pending bits. All other cause bits keep their value.
- R4: A write to status (index 12) stores the full 32-bit value.
- R5: A return-from-exception strobe sets status[3:0] to the old status[5:2]. Status bits 31:4 are unchanged.
- R6: Taking an exception sets status[5:0] to {old status[3:0], 2'b00}. Status bits 31:6 are unchanged.
- R7: Taking an exception writes the code into cause[6:2] and the delay flag into cause[31]. All other cause bits are kept. Code 8 is a system call, 9 a breakpoint and 0 a software interrupt.
- R8: Taking an exception loads index 14 with the faulting PC, or with that PC minus 4 when the delay flag is set.
- R9: `excTaken` is high for exactly the one cycle after the request cycle, and `excCodeOut` carries the code in that cycle.
- R10: The block checks for a software interrupt in the cycle after an accepted write to status or cause. If (cause[9:8] & status[9:8]) is nonzero and status[0] is 1, it takes an exception with code 0, using `excPc`/`excInDelay`. The result shows one cycle later than for a trap.
- R11: No software interrupt is taken when status[0] is 0, when the masks do not overlap, or when the condition arises without a write to status or cause. A write to another index or a return-from-exception does not trigger the check.
- R12: In one cycle an exception (trap or software interrupt) outranks return-from-exception, which outranks a register write. A lower-ranked action in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrIdx | input | 4 | Register index to write |
| wrData | input | 32 | Write data |
| rdIdx | input | 4 | Register index to read |
| rdData | output | 32 | Read data (combinational) |
| rfeReq | input | 1 | Return-from-exception strobe |
| excReq | input | 1 | Trap request |
| excCode | input | 5 | Trap cause code |
| excPc | input | 32 | PC of the faulting instruction |
| excInDelay | input | 1 | Faulting instruction is in a branch delay slot |
| excTaken | output | 1 | One-cycle exception-taken pulse |
| excCodeOut | output | 5 | Code of the exception being reported |

## Verification
The stack push and pop are swept over all 64 values of status[5:0], with fixed high bits. This separates a correct shift from one that loses or duplicates a level, or disturbs bits 5:4 or the upper word. The software-interrupt check is swept over every pairing of the 2-bit pending field, the 2-bit mask and the global enable. This shows whether the decision is a bitwise AND, whether enable gating is present, and whether the decision arrives one cycle after the write. The delay flag alternates, and traps alternate between system call and breakpoint codes, to tell the PC-4 adjustment and cause bit 31 apart from the code field. Directed collisions of trap, return and write in the same cycle confirm the priority order. A pop that re-enables interrupts with no write confirms that the check is tied to writes.

// File: rtl/exc_status_pkg.sv
package exc_status_pkg;
  localparam int DATA_W     = 32;
  localparam int CODE_W     = 5;
  localparam int IDX_W      = 4;
  localparam int NUM_REGS   = 1 << IDX_W;
  localparam int STATUS_IDX = 12;
  localparam int CAUSE_IDX  = 13;
  localparam int EPC_IDX    = 14;
  localparam logic [CODE_W-1:0] CODE_SWI = 5'd0;

  typedef struct packed {
    logic              regWr;
    logic              push;
    logic              pop;
    logic [CODE_W-1:0] code;
    logic              inDelay;
  } dp_strobe_t;
endpackage

// File: rtl/exc_status_ctrl_ctl.sv
module exc_status_ctrl_ctl
  import exc_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              rfeReq,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic [1:0]        swPending,
  input  logic [1:0]        swMask,
  input  logic              globalIe,
  output dp_strobe_t        strb,
  input  logic              excInDelay,
  output logic              excTaken,
  output logic [CODE_W-1:0] excCodeOut
);
  logic swiCheckQ;
  logic swiFire;
  logic take;
  logic hitSwReg;

  assign swiFire  = swiCheckQ && (|(swPending & swMask)) && globalIe;
  assign take     = excReq | swiFire;
  assign hitSwReg = (wrIdx == IDX_W'(STATUS_IDX)) || (wrIdx == IDX_W'(CAUSE_IDX));

  always_comb begin
    strb.push    = take;
    strb.pop     = rfeReq & ~take;
    strb.regWr   = wrEn & ~take & ~rfeReq;
    strb.code    = excReq ? excCode : CODE_SWI;
    strb.inDelay = excInDelay;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swiCheckQ  <= 1'b0;
      excTaken   <= 1'b0;
      excCodeOut <= '0;
    end else begin
      swiCheckQ  <= strb.regWr & hitSwReg;
      excTaken   <= take;
      excCodeOut <= take ? strb.code : excCodeOut;
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.regWr, strb.push, strb.pop})); // R12
  AST_SWI_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && !excReq) |-> $past(wrEn && hitSwReg)); // R10
  AST_TAKEN_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> ($past(excReq) || $past(swiCheckQ))); // R9
endmodule

// File: rtl/exc_status_ctrl_dp.sv
module exc_status_ctrl_dp
  import exc_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] excPc,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        swPending,
  output logic [1:0]        swMask,
  output logic              globalIe
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  assign rdData    = regs[rdIdx];
  assign swPending = regs[CAUSE_IDX][9:8];
  assign swMask    = regs[STATUS_IDX][9:8];
  assign globalIe  = regs[STATUS_IDX][0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              wrHit;
    assign wrHit   = strb.regWr && (wrIdx == IDX_W'(i));
    assign regs[i] = q;

    if (i == STATUS_IDX) begin : g_status
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          q <= '0;
        else if (strb.push) q <= {q[DATA_W-1:6], q[3:0], 2'b00};
        else if (strb.pop)  q <= {q[DATA_W-1:4], q[5:2]};
        else if (wrHit)     q <= wrData;
      end
      AST_RFE_POP: assert property (@(posedge clk) disable iff (!rstN)
        strb.pop |=> (q[3:0] == $past(q[5:2])) && (q[DATA_W-1:4] == $past(q[DATA_W-1:4]))); // R5
      AST_ENTRY_PUSH: assert property (@(posedge clk) disable iff (!rstN)
        strb.push |=> (q[5:0] == {$past(q[3:0]), 2'b00}) && (q[DATA_W-1:6] == $past(q[DATA_W-1:6]))); // R6
    end else if (i == CAUSE_IDX) begin : g_cause
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          q <= '0;
        else if (strb.push) q <= {strb.inDelay, q[DATA_W-2:7], strb.code, q[1:0]};
        else if (wrHit)     q <= {q[DATA_W-1:10], wrData[9:8], q[7:0]};
      end
      AST_CAUSE_SW_ONLY: assert property (@(posedge clk) disable iff (!rstN)
        wrHit |=> (q[DATA_W-1:10] == $past(q[DATA_W-1:10])) && (q[7:0] == $past(q[7:0]))); // R3
    end else if (i == EPC_IDX) begin : g_epc
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          q <= '0;
        else if (strb.push) q <= strb.inDelay ? excPc - DATA_W'(4) : excPc;
        else if (wrHit)     q <= wrData;
      end
      AST_EPC_ADJUST: assert property (@(posedge clk) disable iff (!rstN)
        strb.push |=> q == ($past(strb.inDelay) ? $past(excPc) - DATA_W'(4) : $past(excPc))); // R8
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      q <= '0;
        else if (wrHit) q <= wrData;
      end
    end
  end
endmodule

// File: rtl/exc_status_ctrl.sv
module exc_status_ctrl
  import exc_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  input  logic              rfeReq,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic [DATA_W-1:0] excPc,
  input  logic              excInDelay,
  output logic              excTaken,
  output logic [CODE_W-1:0] excCodeOut
);
  dp_strobe_t strb;
  logic [1:0] swPending;
  logic [1:0] swMask;
  logic       globalIe;

  exc_status_ctrl_ctl u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .rfeReq(rfeReq),
    .excReq(excReq), .excCode(excCode), .swPending(swPending), .swMask(swMask),
    .globalIe(globalIe), .strb(strb), .excInDelay(excInDelay),
    .excTaken(excTaken), .excCodeOut(excCodeOut)
  );

  exc_status_ctrl_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .wrData(wrData),
    .excPc(excPc), .rdIdx(rdIdx), .rdData(rdData), .swPending(swPending),
    .swMask(swMask), .globalIe(globalIe)
  );
endmodule

// File: tb/exc_status_ctrl_tb.sv
module exc_status_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  rdIdx = '0;
  logic [31:0] rdData;
  logic        rfeReq = 1'b0;
  logic        excReq = 1'b0;
  logic [4:0]  excCode = '0;
  logic [31:0] excPc = '0;
  logic        excInDelay = 1'b0;
  logic        excTaken;
  logic [4:0]  excCodeOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  exc_status_ctrl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .rfeReq(rfeReq), .excReq(excReq),
    .excCode(excCode), .excPc(excPc), .excInDelay(excInDelay),
    .excTaken(excTaken), .excCodeOut(excCodeOut)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    rdIdx = 4'(idx);
    #1 v = rdData;
  endtask

  // write, then one idle cycle; returns after the software-interrupt decision edge
  task automatic doWrite(input int idx, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 4'(idx); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic doRfe();
    @(negedge clk);
    rfeReq = 1'b1;
    @(negedge clk);
    rfeReq = 1'b0;
  endtask

  task automatic doExc(input logic [4:0] c, input logic [31:0] pc, input logic dly);
    @(negedge clk);
    excReq = 1'b1; excCode = c; excPc = pc; excInDelay = dly;
    @(negedge clk);
    excReq = 1'b0;
    chk("R9 taken", 32'(excTaken), 32'd1);
    chk("R9 code", 32'(excCodeOut), 32'(c));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, st, ca;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    for (int i = 0; i < 16; i++) begin
      rd(i, v);
      chk("R1 reset reg", v, 32'd0);
    end
    chk("R1 reset taken", 32'(excTaken), 32'd0);

    // R2
    for (int i = 0; i < 16; i++)
      if (i != 12 && i != 13) doWrite(i, 32'h9E37_79B9 * (i + 1));
    for (int i = 0; i < 16; i++)
      if (i != 12 && i != 13) begin
        rd(i, v);
        chk("R2 full write", v, 32'h9E37_79B9 * (i + 1));
      end

    // R4
    doWrite(12, 32'hFFFF_FCFE);
    rd(12, v); chk("R4 status full", v, 32'hFFFF_FCFE);
    doWrite(12, 32'h0);
    rd(12, v); chk("R4 status zero", v, 32'h0);

    // R3
    doWrite(13, 32'hFFFF_FFFF);
    rd(13, v); chk("R3 cause sw only", v, 32'h0000_0300);
    doWrite(13, 32'hFFFF_FCFF);
    rd(13, v); chk("R3 cause clear", v, 32'h0);

    // R5 sweep
    for (int s = 0; s < 64; s++) begin
      doWrite(12, 32'hA5A5_A400 | 32'(s));
      doRfe();
      rd(12, v);
      chk("R5 pop", v, {26'h2969690, 2'(s >> 4), 4'(s >> 2)} );
    end

    // R6 R7 R8 sweep
    doWrite(12, 32'h0);
    doWrite(13, 32'h300);
    for (int s = 0; s < 64; s++) begin
      logic dly;
      logic [4:0] c;
      dly = s[0];
      c = s[1] ? 5'd9 : 5'd8;
      doWrite(12, 32'hA5A5_A400 | 32'(s));
      rd(13, ca);
      doExc(c, 32'h1000 + 32'(s) * 4, dly);
      rd(12, v);
      chk("R6 push", v, {26'h2969690, 4'(s), 2'b00});
      rd(13, v);
      chk("R7 cause", v, {dly, ca[30:7], c, ca[1:0]});
      rd(14, v);
      chk("R8 epc", v, dly ? 32'h1000 + 32'(s) * 4 - 4 : 32'h1000 + 32'(s) * 4);
      @(negedge clk);
      chk("R9 pulse ends", 32'(excTaken), 32'd0);
    end

    // R10 R11 sweep
    excPc = 32'h2000; excInDelay = 1'b0;
    for (int c = 0; c < 4; c++)
      for (int m = 0; m < 4; m++)
        for (int ie = 0; ie < 2; ie++) begin
          bit fire;
          fire = ((c & m) != 0) && (ie == 1);
          doWrite(12, 32'h0);
          doWrite(13, 32'(c) << 8);
          doWrite(12, (32'(m) << 8) | 32'(ie));
          chk(fire ? "R10 swi taken" : "R11 swi blocked", 32'(excTaken), 32'(fire));
          rd(12, v);
          chk("R10 status after", v, fire ? ((32'(m) << 8) | 32'h4) : ((32'(m) << 8) | 32'(ie)));
          if (fire) begin
            chk("R10 swi code", 32'(excCodeOut), 32'd0);
            rd(13, v); chk("R10 cause code", v, 32'(c) << 8);
            rd(14, v); chk("R10 epc", v, 32'h2000);
          end
        end
    // R10 via cause write
    doWrite(13, 32'h0);
    doWrite(12, 32'h201);
    chk("R11 no pending", 32'(excTaken), 32'd0);
    doWrite(13, 32'h200);
    chk("R10 cause write fires", 32'(excTaken), 32'd1);
    // R11 rfe re-enables without a write: no interrupt
    doRfe();
    @(negedge clk);
    chk("R11 rfe no swi", 32'(excTaken), 32'd0);
    rd(12, v); chk("R11 ie back", v, 32'h201);
    doWrite(5, 32'h1234);
    chk("R11 other reg no swi", 32'(excTaken), 32'd0);

    // R12
    doWrite(12, 32'h0000_0005);
    @(negedge clk);
    excReq = 1'b1; excCode = 5'd8; excPc = 32'h3000; excInDelay = 1'b0;
    wrEn = 1'b1; wrIdx = 4'd14; wrData = 32'hDEAD_BEEF; rfeReq = 1'b1;
    @(negedge clk);
    excReq = 1'b0; wrEn = 1'b0; rfeReq = 1'b0;
    rd(14, v); chk("R12 exc beats write", v, 32'h3000);
    rd(12, v); chk("R12 exc beats rfe", v, 32'h0000_0014);
    @(negedge clk);
    rfeReq = 1'b1; wrEn = 1'b1; wrIdx = 4'd12; wrData = 32'h0;
    @(negedge clk);
    rfeReq = 1'b0; wrEn = 1'b0;
    rd(12, v); chk("R12 rfe beats write", v, 32'h0000_0015);
    st = v;
    @(negedge clk);
    chk("R12 no swi from dropped write", 32'(excTaken), 32'd0);
    rd(12, v); chk("R12 status stable", v, st);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule